// File: doc/BRIEF.md
# Hold/Acknowledge Bus Requester

This block is the front end that a DMA master uses to win the system bus from a host processor over a two-wire handshake. The master raises `hold`, and the processor answers on `hlda`. Internal sources ask for the bus. One source is a FIFO threshold, which means data-area traffic. The other is a pending descriptor access, which is either an ordinary descriptor table or an address-filter (CAM) load. The block picks one request, tags it with an area class and runs the handshake. It gives the DMA engine a bus-owned enable for the cycles in which the engine may drive the bus.

The processor can take the bus back at any time by dropping `hlda` while `hold` is still high. What happens next depends on the area that was interrupted:

- **Descriptor work:** the block retries after a single clock with `hold` low.
- **Data work:** the block retries only if the FIFO still asks for service.
- **CAM load:** the block leaves the bus but keeps `hold` high, and its activity status reads idle.

When a transfer completes normally, the block spends one holding cycle before it lets go, so it never overlaps the next master. A phase input picks the launch edge for `hold`: the falling edge of the clock, or the rising edge half a clock later.

All pins are plain control and status levels. Nothing here moves a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_hold_req`

## Requirements
- R1: While `rst` is high (synchronous, active high), `hold`, `bus_own`, `active` and `preempted` are all low.
- R2: A pending descriptor request wins over the FIFO threshold. The granted area appears on `own_area` as 0 for data, 1 for a descriptor table and 2 for a CAM load (`desc_req` with `desc_is_cam` high).
- R3: A new request never starts while `hlda` is sampled high. `hold` stays low until `hlda` has been sampled low.
- R4: With `phase_late` low, `hold` follows the internal decision on the next falling clock edge. With `phase_late` high, it follows on the rising edge after that.
- R5: `bus_own` rises only on the rising edge after `hlda` was sampled high while requesting. It is high only while the bus is owned, and never while `hlda` is forced low.
- R6: A `xfer_done` pulse while the bus is owned ends the transfer. The next cycle is a holding cycle, with `bus_own` low, `hold` low and `active` high. The block is idle one cycle later, so a request for a new area always starts with `hold` low.
- R7: If the bus is lost during descriptor-table work, `hold` drops for exactly one cycle and is then raised again without any new request.
- R8: If the bus is lost during data work, `hold` is raised again only if `thresh_hit` is still high. Otherwise the block goes idle.
- R9: If the bus is lost during a CAM load, `bus_own` drops, `hold` stays high and `active` reads low. A new grant resumes ownership.
- R10: Losing the bus sets `preempted` and stores the area on `preempt_area`. Both hold until a later transfer of the same area completes.
- R11: If `hlda` drops on the same edge that `xfer_done` arrives, the loss of the bus takes precedence over completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_late | input | 1 | 1 launches `hold` on the rising edge instead of the falling edge |
| thresh_hit | input | 1 | FIFO threshold reached (data-area request) |
| desc_req | input | 1 | Descriptor access pending |
| desc_is_cam | input | 1 | Pending descriptor access is a CAM load |
| xfer_done | input | 1 | Last DMA cycle of the current block transfer |
| hlda | input | 1 | Hold acknowledge from the processor |
| hold | output | 1 | Hold request to the processor |
| bus_own | output | 1 | DMA engine may drive the bus |
| own_area | output | 2 | Area class of the current or last request |
| active | output | 1 | Status: the requester is busy |
| preempted | output | 1 | Sticky flag: an access was interrupted |
| preempt_area | output | 2 | Area class of the interrupted access |

## Verification
The main path is exercised with several patterns:

- Threshold alone, descriptor alone, and both requests together, which separate the priority order and the three area codes.
- `hlda` held high before any request, which distinguishes a requester that checks acknowledge first from one that raises `hold` blindly.
- Launch timing measured in both phase settings.

Preemption is driven in each area class. For data, the threshold is either kept or withdrawn. This separates the three re-request rules from one another. A final case drops `hlda` on the same edge as `xfer_done`, to fix the precedence. A behavioural model in the bench predicts every output on every clock.

// File: rtl/bhr_pkg.sv
package bhr_pkg;

  typedef enum logic [1:0] {
    AREA_DATA = 2'd0,
    AREA_DESC = 2'd1,
    AREA_CAM  = 2'd2
  } area_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_OWN     = 3'd2,
    ST_RETRY   = 3'd3,
    ST_PARK    = 3'd4,
    ST_HOLDOFF = 3'd5
  } st_e;

endpackage

// File: rtl/bhr_select.sv
// Picks one pending source and tags it with an area class.
module bhr_select
  import bhr_pkg::*;
(
  input  logic  thresh_hit,
  input  logic  desc_req,
  input  logic  desc_is_cam,
  output logic  any_req,
  output area_e req_area
);
  always_comb begin
    any_req = thresh_hit | desc_req;
    if (desc_req) begin
      req_area = desc_is_cam ? AREA_CAM : AREA_DESC;
    end else begin
      req_area = AREA_DATA;
    end
  end
endmodule

// File: rtl/bhr_fsm.sv
// Handshake sequencer: request, own, holding cycle, and the
// area-dependent reaction to a lost grant.
module bhr_fsm
  import bhr_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 1,
  parameter int unsigned RETRY_GAP   = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  hlda,
  input  logic  any_req,
  input  area_e req_area,
  input  logic  thresh_hit,
  input  logic  xfer_done,
  output logic  hold_intent,
  output logic  bus_own,
  output logic  active,
  output logic  pre_evt,
  output logic  done_evt,
  output area_e cur_area
);
  localparam int unsigned MAXC  = (HOLDOFF_CYC > RETRY_GAP) ? HOLDOFF_CYC : RETRY_GAP;
  localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  st_e              st_q, st_d;
  area_e            area_q, area_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_done, gap_done;

  assign hold_done = (32'(cnt_q) + 32'd1) >= HOLDOFF_CYC;
  assign gap_done  = (32'(cnt_q) + 32'd1) >= RETRY_GAP;

  always_comb begin
    st_d   = st_q;
    area_d = area_q;
    cnt_d  = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (any_req && !hlda) begin
          st_d   = ST_REQ;
          area_d = req_area;
        end
      end
      ST_REQ: begin
        if (hlda) st_d = ST_OWN;
      end
      ST_OWN: begin
        if (!hlda) begin
          cnt_d = '0;
          st_d  = (area_q == AREA_CAM) ? ST_PARK : ST_RETRY;
        end else if (xfer_done) begin
          cnt_d = '0;
          st_d  = ST_HOLDOFF;
        end
      end
      ST_PARK: begin
        if (hlda) st_d = ST_OWN;
      end
      ST_RETRY: begin
        if (!gap_done) begin
          cnt_d = cnt_q + CNT_W'(1);
        end else if (area_q == AREA_DATA && !thresh_hit) begin
          st_d = ST_IDLE;
        end else if (!hlda) begin
          st_d = ST_REQ;
        end
      end
      ST_HOLDOFF: begin
        if (!hold_done) cnt_d = cnt_q + CNT_W'(1);
        else            st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      area_q <= AREA_DATA;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      area_q <= area_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hold_intent = (st_q == ST_REQ) || (st_q == ST_OWN) || (st_q == ST_PARK);
  assign bus_own     = (st_q == ST_OWN);
  assign active      = (st_q == ST_REQ) || (st_q == ST_OWN) ||
                       (st_q == ST_RETRY) || (st_q == ST_HOLDOFF);
  assign pre_evt     = (st_q == ST_OWN) && !hlda;
  assign done_evt    = (st_q == ST_OWN) && hlda && xfer_done;
  assign cur_area    = area_q;
endmodule

// File: rtl/bhr_launch.sv
// Launches the hold pin on the falling edge, or half a clock later
// on the rising edge when the late phase is selected.
module bhr_launch (
  input  logic clk,
  input  logic rst,
  input  logic phase_late,
  input  logic intent,
  output logic hold
);
  logic fall_q, rise_q;

  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= intent;
  end

  always_ff @(posedge clk) begin
    if (rst) rise_q <= 1'b0;
    else     rise_q <= fall_q;
  end

  assign hold = phase_late ? rise_q : fall_q;
endmodule

// File: rtl/bhr_plog.sv
// Sticky record of an interrupted access and its area class.
module bhr_plog
  import bhr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pre_evt,
  input  logic  done_evt,
  input  area_e area,
  output logic  preempted,
  output area_e pre_area
);
  always_ff @(posedge clk) begin
    if (rst) begin
      preempted <= 1'b0;
      pre_area  <= AREA_DATA;
    end else if (pre_evt) begin
      preempted <= 1'b1;
      pre_area  <= area;
    end else if (done_evt && preempted && (pre_area == area)) begin
      preempted <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_hold_req.sv
module bus_hold_req
  import bhr_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 1,
  parameter int unsigned RETRY_GAP   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_late,
  input  logic       thresh_hit,
  input  logic       desc_req,
  input  logic       desc_is_cam,
  input  logic       xfer_done,
  input  logic       hlda,
  output logic       hold,
  output logic       bus_own,
  output logic [1:0] own_area,
  output logic       active,
  output logic       preempted,
  output logic [1:0] preempt_area
);
  logic  any_req, hold_intent, pre_evt, done_evt;
  area_e req_area, cur_area, pre_area;

  bhr_select u_sel (
    .thresh_hit (thresh_hit),
    .desc_req   (desc_req),
    .desc_is_cam(desc_is_cam),
    .any_req    (any_req),
    .req_area   (req_area)
  );

  bhr_fsm #(
    .HOLDOFF_CYC(HOLDOFF_CYC),
    .RETRY_GAP  (RETRY_GAP)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .hlda       (hlda),
    .any_req    (any_req),
    .req_area   (req_area),
    .thresh_hit (thresh_hit),
    .xfer_done  (xfer_done),
    .hold_intent(hold_intent),
    .bus_own    (bus_own),
    .active     (active),
    .pre_evt    (pre_evt),
    .done_evt   (done_evt),
    .cur_area   (cur_area)
  );

  bhr_launch u_launch (
    .clk       (clk),
    .rst       (rst),
    .phase_late(phase_late),
    .intent    (hold_intent),
    .hold      (hold)
  );

  bhr_plog u_plog (
    .clk      (clk),
    .rst      (rst),
    .pre_evt  (pre_evt),
    .done_evt (done_evt),
    .area     (cur_area),
    .preempted(preempted),
    .pre_area (pre_area)
  );

  assign own_area     = cur_area;
  assign preempt_area = pre_area;
endmodule

// File: rtl/bus_hold_req_chk.sv
module bus_hold_req_chk (
  input logic       clk,
  input logic       rst,
  input logic       phase_late,
  input logic       hlda,
  input logic       hold,
  input logic       bus_own,
  input logic       active,
  input logic       preempted,
  input logic [1:0] preempt_area,
  input logic       intent
);
  a_r5_own_after_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> $past(hlda));

  a_r5_own_implies_request: assert property (@(posedge clk) disable iff (rst)
    bus_own |-> (intent && active));

  a_r3_no_raise_on_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(intent) |-> !$past(hlda));

  a_r6_holding_cycle: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_own) && $past(hlda)) |=> !bus_own);

  a_r9_parked_flagged: assert property (@(posedge clk) disable iff (rst)
    (intent && !bus_own && !active) |-> (preempted && preempt_area == 2'd2));

  a_r10_flag_on_loss: assert property (@(posedge clk) disable iff (rst)
    $rose(preempted) |-> ($past(bus_own) && !$past(hlda)));

  a_r4_fall_launch: assert property (@(posedge clk) disable iff (rst)
    (!phase_late && !$past(rst)) |-> (hold == intent));

  a_r4_rise_launch: assert property (@(posedge clk) disable iff (rst)
    (phase_late && !$past(rst) && !$past(rst, 2)) |-> (hold == $past(intent)));
endmodule

bind bus_hold_req bus_hold_req_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .phase_late  (phase_late),
  .hlda        (hlda),
  .hold        (hold),
  .bus_own     (bus_own),
  .active      (active),
  .preempted   (preempted),
  .preempt_area(preempt_area),
  .intent      (hold_intent)
);

// File: tb/sim_bus_hold_req.sv
module sim_bus_hold_req;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phase_late = 1'b0, thresh_hit = 1'b0, desc_req = 1'b0;
  logic       desc_is_cam = 1'b0, xfer_done = 1'b0, hlda = 1'b0;
  logic       hold, bus_own, active, preempted;
  logic [1:0] own_area, preempt_area;

  int checks = 0, errors = 0, cycles = 0;
  logic allow = 1'b1, force_en = 1'b0, force_val = 1'b0;

  // behavioural reference state
  int   ms = 0, ma = 0, mpa = 0;
  logic mpre = 1'b0, mhn = 1'b0, mhp = 1'b0;

  always #5 clk = ~clk;

  bus_hold_req u0 (
    .clk(clk), .rst(rst), .phase_late(phase_late), .thresh_hit(thresh_hit),
    .desc_req(desc_req), .desc_is_cam(desc_is_cam), .xfer_done(xfer_done),
    .hlda(hlda), .hold(hold), .bus_own(bus_own), .own_area(own_area),
    .active(active), .preempted(preempted), .preempt_area(preempt_area)
  );

  // processor model: grants while hold is seen, unless told otherwise
  always @(posedge clk) begin
    #2;
    hlda = force_en ? force_val : ((hold === 1'b1) && allow);
  end

  // reference model: request, own, holding cycle, retry per area
  always @(negedge clk) mhn <= rst ? 1'b0 : (ms == 1 || ms == 2 || ms == 4);

  always @(posedge clk) begin
    if (rst) begin
      ms <= 0; ma <= 0; mpre <= 1'b0; mpa <= 0; mhp <= 1'b0;
    end else begin
      mhp <= mhn;
      case (ms)
        0: if ((desc_req || thresh_hit) && !hlda) begin
             ms <= 1;
             ma <= desc_req ? (desc_is_cam ? 2 : 1) : 0;
           end
        1: if (hlda) ms <= 2;
        2: if (!hlda) begin
             mpre <= 1'b1; mpa <= ma; ms <= (ma == 2) ? 4 : 3;
           end else if (xfer_done) begin
             ms <= 5;
             if (mpre && mpa == ma) mpre <= 1'b0;
           end
        3: if (ma == 0 && !thresh_hit) ms <= 0;
           else if (!hlda) ms <= 1;
        4: if (hlda) ms <= 2;
        default: ms <= 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #7;
    if (!rst) begin
      chk("R4 hold", {3'b0, hold}, {3'b0, phase_late ? mhp : mhn});
      chk("R5 bus_own", {3'b0, bus_own}, {3'b0, ms == 2});
      chk("R2 own_area", {2'b0, own_area}, 4'(ma));
      chk("R6 active", {3'b0, active}, {3'b0, (ms == 1 || ms == 2 || ms == 3 || ms == 5)});
      chk("R10 preempted", {3'b0, preempted}, {3'b0, mpre});
      chk("R10 preempt_area", {2'b0, preempt_area}, 4'(mpa));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog all-reqs act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #8;
  endtask

  task automatic wait_own(input string tag);
    int n = 0;
    while (!bus_own && n < 50) begin
      cyc();
      n++;
    end
    chk(tag, {3'b0, bus_own}, 4'd1);
  endtask

  task automatic finish_xfer();
    xfer_done = 1'b1; thresh_hit = 1'b0; desc_req = 1'b0; desc_is_cam = 1'b0;
    cyc();
    xfer_done = 1'b0;
    repeat (3) cyc();
  endtask

  initial begin
    repeat (3) cyc();
    chk("R1 hold", {3'b0, hold}, 4'd0);
    chk("R1 bus_own", {3'b0, bus_own}, 4'd0);
    chk("R1 active", {3'b0, active}, 4'd0);
    chk("R1 preempted", {3'b0, preempted}, 4'd0);
    rst = 1'b0;
    repeat (2) cyc();

    // R2 / R6: data transfer and the holding cycle
    thresh_hit = 1'b1;
    wait_own("R5 grant data");
    chk("R2 data area", {2'b0, own_area}, 4'd0);
    repeat (2) cyc();
    xfer_done = 1'b1; thresh_hit = 1'b0;
    cyc();
    chk("R6 hold cycle own", {3'b0, bus_own}, 4'd0);
    chk("R6 hold cycle active", {3'b0, active}, 4'd1);
    chk("R6 hold cycle hold", {3'b0, hold}, 4'd0);
    xfer_done = 1'b0;
    cyc();
    chk("R6 idle after", {3'b0, active}, 4'd0);
    repeat (2) cyc();

    // R2: descriptor wins over threshold; CAM code
    thresh_hit = 1'b1; desc_req = 1'b1;
    wait_own("R5 grant desc");
    chk("R2 desc priority", {2'b0, own_area}, 4'd1);
    finish_xfer();
    desc_req = 1'b1; desc_is_cam = 1'b1;
    wait_own("R5 grant cam");
    chk("R2 cam area", {2'b0, own_area}, 4'd2);
    finish_xfer();

    // R3: acknowledge already high blocks the request
    force_en = 1'b1; force_val = 1'b1;
    cyc();
    thresh_hit = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R3 hold blocked", {3'b0, hold}, 4'd0);
    end
    force_en = 1'b0;
    wait_own("R3 request after release");
    finish_xfer();

    // R4 / R5: launch edge, no ownership without grant
    force_en = 1'b1; force_val = 1'b0;
    cyc();
    thresh_hit = 1'b1;
    cyc();
    chk("R4 early launch", {3'b0, hold}, 4'd1);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R5 no grant no own", {3'b0, bus_own}, 4'd0);
    end
    force_en = 1'b0;
    wait_own("R5 late grant");
    finish_xfer();
    phase_late = 1'b1;
    force_en = 1'b1; force_val = 1'b0;
    cyc();
    thresh_hit = 1'b1;
    cyc();
    chk("R4 late not yet", {3'b0, hold}, 4'd0);
    cyc();
    chk("R4 late launch", {3'b0, hold}, 4'd1);
    force_en = 1'b0;
    wait_own("R5 grant late phase");
    finish_xfer();
    phase_late = 1'b0;
    cyc();

    // R7: descriptor preempt, single-cycle drop
    desc_req = 1'b1;
    wait_own("R5 grant desc2");
    allow = 1'b0;
    cyc();
    cyc();
    chk("R7 off bus", {3'b0, bus_own}, 4'd0);
    chk("R7 hold low", {3'b0, hold}, 4'd0);
    chk("R10 flag desc", {preempted, 1'b0, preempt_area}, 4'b1001);
    allow = 1'b1;
    cyc();
    chk("R7 hold back", {3'b0, hold}, 4'd1);
    wait_own("R7 regain");
    chk("R10 flag kept", {3'b0, preempted}, 4'd1);
    finish_xfer();
    chk("R10 flag cleared desc", {3'b0, preempted}, 4'd0);

    // R8: data preempt with threshold still high
    thresh_hit = 1'b1;
    wait_own("R5 grant data2");
    allow = 1'b0;
    cyc();
    cyc();
    chk("R8 hold low", {3'b0, hold}, 4'd0);
    allow = 1'b1;
    cyc();
    chk("R8 re-request", {3'b0, hold}, 4'd1);
    wait_own("R8 regain");
    finish_xfer();
    chk("R10 cleared data", {3'b0, preempted}, 4'd0);

    // R8: data preempt after threshold withdrawn
    thresh_hit = 1'b1;
    wait_own("R5 grant data3");
    allow = 1'b0; thresh_hit = 1'b0;
    cyc(); cyc(); cyc();
    chk("R8 idle", {3'b0, active}, 4'd0);
    allow = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R8 stays off", {3'b0, hold}, 4'd0);
    end
    chk("R10 flag data", {preempted, 1'b0, preempt_area}, 4'b1000);
    thresh_hit = 1'b1;
    wait_own("R8 new data");
    finish_xfer();
    chk("R10 cleared later", {3'b0, preempted}, 4'd0);

    // R9: CAM preempt parks with hold high
    desc_req = 1'b1; desc_is_cam = 1'b1;
    wait_own("R5 grant cam2");
    allow = 1'b0;
    cyc();
    cyc();
    chk("R9 off bus", {3'b0, bus_own}, 4'd0);
    chk("R9 hold kept", {3'b0, hold}, 4'd1);
    chk("R9 status idle", {3'b0, active}, 4'd0);
    chk("R10 flag cam", {preempted, 1'b0, preempt_area}, 4'b1010);
    repeat (2) cyc();
    chk("R9 hold still", {3'b0, hold}, 4'd1);
    allow = 1'b1;
    wait_own("R9 resume");
    finish_xfer();
    chk("R10 cleared cam", {3'b0, preempted}, 4'd0);

    // R11: loss of grant beats completion on the same edge
    thresh_hit = 1'b1;
    wait_own("R5 grant data4");
    allow = 1'b0; thresh_hit = 1'b0;
    cyc();
    xfer_done = 1'b1;
    cyc();
    xfer_done = 1'b0;
    chk("R11 preempt wins", {preempted, bus_own, active, hold}, 4'b1010);
    allow = 1'b1;
    repeat (3) cyc();
    thresh_hit = 1'b1;
    wait_own("R11 recover");
    finish_xfer();
    repeat (3) cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule